// File: doc/BRIEF.md
# Peripheral RAM and I/O Port Core

This block is the bus-facing core of a small peripheral device. It holds 128 bytes of static scratch memory and two 8-bit general-purpose ports. Each port has an output value register and a drive-enable (direction) register. A host reaches all of them through a single 7-bit address space. An active-low memory select steers an access to the scratch memory. With the memory select inactive, address bit 2 separates the port register group from a group that belongs to a neighbouring timer/interrupt block.

An access takes place only when the active-high chip enable is high and the active-low chip enable is low. Writes update storage on the rising clock edge. Read data is combinational from the address and the select lines, and a data output enable marks the cycles in which the host may sample it. A read of a port's value address returns the level on the pin, not the register contents: driven bits show the output register and undriven bits show the external level. When an access falls in the neighbour's group, the block raises a decode strobe and passes the neighbour's read data through to the bus.

Top module: `periph_io_core`

## Requirements
- R1: An access occurs only when `chip_en` is 1 and `chip_en_n` is 0. Otherwise no RAM byte or port register changes and `rdata_oe` stays 0.
- R2: With `mem_sel_n` = 0, `addr[6:0]` selects one of 128 bytes. `rd_wr` = 0 writes `wdata` at the clock edge, and `rd_wr` = 1 returns the stored byte on `rdata`.
- R3: With `mem_sel_n` = 1 and `addr[2]` = 0, the register is selected by `addr[1:0]` and `addr[6:3]` is ignored: 0 is port 0 value, 1 is port 0 direction, 2 is port 1 value, 3 is port 1 direction.
- R4: Each `gpioN_oe` bit equals the matching direction register bit (1 = output, 0 = input), and `gpioN_out` equals the value register.
- R5: A read of a port value address returns, per bit, the value register bit where the direction bit is 1 and the `gpioN_in` bit where it is 0.
- R6: A read of a direction address returns the direction register contents.
- R7: A synchronous reset (`rst` = 1 at a clock edge) clears both value registers and both direction registers, so every pin becomes an input.
- R8: `rdata_oe` is 1 only during a selected read with `rst` low. It is 0 while reset is held.
- R9: With `mem_sel_n` = 1 and `addr[2]` = 1 in a selected cycle, `aux_sel` is 1 and a read returns `aux_rdata`. A write there changes no port register and no RAM byte.
- R10: A RAM write leaves the port registers unchanged, and a port register write leaves the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| chip_en | input | 1 | Chip enable, active high |
| chip_en_n | input | 1 | Chip enable, active low |
| mem_sel_n | input | 1 | Scratch memory select, active low |
| addr | input | 7 | Access address |
| rd_wr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| rdata_oe | output | 1 | Read data output enable |
| aux_sel | output | 1 | Decode strobe to the timer/interrupt block |
| aux_rdata | input | 8 | Read data from the timer/interrupt block |
| gpio0_in | input | 8 | External levels on port 0 pins (1 when undriven) |
| gpio0_out | output | 8 | Port 0 output values |
| gpio0_oe | output | 8 | Port 0 drive enables |
| gpio1_in | input | 8 | External levels on port 1 pins (1 when undriven) |
| gpio1_out | output | 8 | Port 1 output values |
| gpio1_oe | output | 8 | Port 1 drive enables |

## Verification
The assertions assume that the select, address, direction and write data lines are stable across each rising edge, and that the neighbour's read data is valid whenever the decode strobe is high. The bench changes every input only on the falling edge and holds it through the following rising edge. It drives a fixed value on `aux_rdata` during neighbour accesses. External pin levels are changed only between accesses, so every combinational read is sampled after the inputs have settled.

// File: rtl/periph_io_pkg.sv
package periph_io_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 7;
    localparam int NUM_PORTS = 2;
    localparam int MEM_DEPTH = 1 << ADDR_W;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_MEM  = 2'd1,
        ACC_PORT = 2'd2,
        ACC_AUX  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e kind;
        logic      port_idx;
        logic      is_dir;
    } acc_dec_t;

    // Per-bit pin level: driven bits show the register, others the pad.
    function automatic logic [DATA_W-1:0] pin_level(
        input logic [DATA_W-1:0] dir,
        input logic [DATA_W-1:0] val,
        input logic [DATA_W-1:0] pad
    );
        return (dir & val) | (~dir & pad);
    endfunction

endpackage

// File: rtl/periph_io_decode.sv
module periph_io_decode
    import periph_io_pkg::*;
(
    input  logic       chip_en,
    input  logic       chip_en_n,
    input  logic       mem_sel_n,
    input  logic [2:0] addr_lo,
    output acc_dec_t   dec
);
    always_comb begin
        dec.kind     = ACC_NONE;
        dec.port_idx = addr_lo[1];
        dec.is_dir   = addr_lo[0];
        if (chip_en && !chip_en_n) begin
            if (!mem_sel_n)      dec.kind = ACC_MEM;
            else if (addr_lo[2]) dec.kind = ACC_AUX;
            else                 dec.kind = ACC_PORT;
        end
    end
endmodule

// File: rtl/periph_io_mem.sv
module periph_io_mem
    import periph_io_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] store [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[addr] <= wdata;
    end

    assign rdata = store[addr];
endmodule

// File: rtl/periph_io_port.sv
module periph_io_port
    import periph_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_val,
    input  logic              wr_dir,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pad_in,
    output logic [DATA_W-1:0] val_q,
    output logic [DATA_W-1:0] dir_q,
    output logic [DATA_W-1:0] level
);
    always_ff @(posedge clk) begin
        if (rst) begin
            val_q <= '0;
            dir_q <= '0;
        end else begin
            if (wr_val) val_q <= wdata;
            if (wr_dir) dir_q <= wdata;
        end
    end

    assign level = pin_level(dir_q, val_q, pad_in);
endmodule

// File: rtl/periph_io_core.sv
module periph_io_core
    import periph_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              chip_en_n,
    input  logic              mem_sel_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe,
    output logic              aux_sel,
    input  logic [DATA_W-1:0] aux_rdata,
    input  logic [DATA_W-1:0] gpio0_in,
    output logic [DATA_W-1:0] gpio0_out,
    output logic [DATA_W-1:0] gpio0_oe,
    input  logic [DATA_W-1:0] gpio1_in,
    output logic [DATA_W-1:0] gpio1_out,
    output logic [DATA_W-1:0] gpio1_oe
);
    acc_dec_t          dec;
    logic              do_wr;
    logic [DATA_W-1:0] mem_rd;
    logic [DATA_W-1:0] pad   [NUM_PORTS];
    logic [DATA_W-1:0] val_q [NUM_PORTS];
    logic [DATA_W-1:0] dir_q [NUM_PORTS];
    logic [DATA_W-1:0] level [NUM_PORTS];

    periph_io_decode u_dec (
        .chip_en   (chip_en),
        .chip_en_n (chip_en_n),
        .mem_sel_n (mem_sel_n),
        .addr_lo   (addr[2:0]),
        .dec       (dec)
    );

    assign do_wr = (dec.kind != ACC_NONE) && !rd_wr;

    periph_io_mem u_mem (
        .clk   (clk),
        .we    (do_wr && dec.kind == ACC_MEM),
        .addr  (addr),
        .wdata (wdata),
        .rdata (mem_rd)
    );

    assign pad[0] = gpio0_in;
    assign pad[1] = gpio1_in;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        logic hit;
        assign hit = do_wr && dec.kind == ACC_PORT && dec.port_idx == p[0];
        periph_io_port u_port (
            .clk    (clk),
            .rst    (rst),
            .wr_val (hit && !dec.is_dir),
            .wr_dir (hit && dec.is_dir),
            .wdata  (wdata),
            .pad_in (pad[p]),
            .val_q  (val_q[p]),
            .dir_q  (dir_q[p]),
            .level  (level[p])
        );
    end

    assign gpio0_out = val_q[0];
    assign gpio0_oe  = dir_q[0];
    assign gpio1_out = val_q[1];
    assign gpio1_oe  = dir_q[1];

    always_comb begin
        unique case (dec.kind)
            ACC_MEM:  rdata = mem_rd;
            ACC_PORT: rdata = dec.is_dir ? dir_q[dec.port_idx] : level[dec.port_idx];
            ACC_AUX:  rdata = aux_rdata;
            default:  rdata = '0;
        endcase
    end

    assign aux_sel  = (dec.kind == ACC_AUX);
    assign rdata_oe = (dec.kind != ACC_NONE) && rd_wr && !rst;
endmodule

// File: rtl/periph_io_core_chk.sv
module periph_io_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       chip_en,
    input logic       chip_en_n,
    input logic       mem_sel_n,
    input logic [6:0] addr,
    input logic       rd_wr,
    input logic [7:0] rdata,
    input logic       rdata_oe,
    input logic       aux_sel,
    input logic [7:0] aux_rdata,
    input logic [7:0] gpio0_out,
    input logic [7:0] gpio0_oe,
    input logic [7:0] gpio1_out,
    input logic [7:0] gpio1_oe
);
    logic past_valid = 1'b0;
    always_ff @(posedge clk) past_valid <= 1'b1;

    wire selected = chip_en && !chip_en_n;

    assert_oe_only_sel_read_R8: assert property (@(posedge clk)
        rdata_oe |-> (selected && rd_wr && !rst));

    assert_rst_clears_R7: assert property (@(posedge clk)
        (past_valid && $past(rst)) |->
        (gpio0_out == 8'h00 && gpio0_oe == 8'h00 && gpio1_out == 8'h00 && gpio1_oe == 8'h00));

    assert_unsel_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !selected |=> ($stable(gpio0_out) && $stable(gpio0_oe) &&
                       $stable(gpio1_out) && $stable(gpio1_oe)));

    assert_mem_wr_no_port_R10: assert property (@(posedge clk) disable iff (rst)
        (selected && !mem_sel_n && !rd_wr) |=> ($stable(gpio0_out) && $stable(gpio0_oe) &&
                                                $stable(gpio1_out) && $stable(gpio1_oe)));

    assert_aux_decode_R9: assert property (@(posedge clk) disable iff (rst)
        aux_sel |-> (selected && mem_sel_n && addr[2]));

    assert_aux_data_R9: assert property (@(posedge clk) disable iff (rst)
        (aux_sel && rd_wr) |-> (rdata == aux_rdata));

    assert_aux_wr_no_port_R9: assert property (@(posedge clk) disable iff (rst)
        (aux_sel && !rd_wr) |=> ($stable(gpio0_out) && $stable(gpio0_oe) &&
                                 $stable(gpio1_out) && $stable(gpio1_oe)));
endmodule

bind periph_io_core periph_io_core_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .chip_en   (chip_en),
    .chip_en_n (chip_en_n),
    .mem_sel_n (mem_sel_n),
    .addr      (addr),
    .rd_wr     (rd_wr),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe),
    .aux_sel   (aux_sel),
    .aux_rdata (aux_rdata),
    .gpio0_out (gpio0_out),
    .gpio0_oe  (gpio0_oe),
    .gpio1_out (gpio1_out),
    .gpio1_oe  (gpio1_oe)
);

// File: tb/periph_io_core_tb.sv
module periph_io_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       chip_en = 1'b0, chip_en_n = 1'b1, mem_sel_n = 1'b1, rd_wr = 1'b1;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0, aux_rdata = '0;
    logic [7:0] gpio0_in = 8'hFF, gpio1_in = 8'hFF;
    logic [7:0] rdata, gpio0_out, gpio0_oe, gpio1_out, gpio1_oe;
    logic       rdata_oe, aux_sel;

    int checks = 0, failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    periph_io_core u_dut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .chip_en_n(chip_en_n),
        .mem_sel_n(mem_sel_n), .addr(addr), .rd_wr(rd_wr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .aux_sel(aux_sel), .aux_rdata(aux_rdata),
        .gpio0_in(gpio0_in), .gpio0_out(gpio0_out), .gpio0_oe(gpio0_oe),
        .gpio1_in(gpio1_in), .gpio1_out(gpio1_out), .gpio1_oe(gpio1_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic idle();
        chip_en = 1'b0; chip_en_n = 1'b1; rd_wr = 1'b1; mem_sel_n = 1'b1;
    endtask

    task automatic bus_wr(input logic ce, input logic ce_n, input logic msn,
                          input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        chip_en = ce; chip_en_n = ce_n; mem_sel_n = msn; addr = a; rd_wr = 1'b0; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic bus_rd(input logic msn, input logic [6:0] a,
                          output logic [7:0] q, output logic oe);
        @(negedge clk);
        chip_en = 1'b1; chip_en_n = 1'b0; mem_sel_n = msn; addr = a; rd_wr = 1'b1;
        #1;
        q = rdata; oe = rdata_oe;
    endtask

    function automatic logic [7:0] mem_pat(input int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    initial begin
        #(8 * 200000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] q;
        logic       oe;
        logic [7:0] save_v, save_d;

        // Reset with a selected read held: R8 oe low, R7 registers clear
        chip_en = 1'b1; chip_en_n = 1'b0; rd_wr = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check("R8 oe in reset", {7'b0, rdata_oe}, 8'h00);
        check("R7 gpio0_oe reset", gpio0_oe, 8'h00);
        check("R7 gpio1_oe reset", gpio1_oe, 8'h00);
        check("R7 gpio0_out reset", gpio0_out, 8'h00);
        check("R7 gpio1_out reset", gpio1_out, 8'h00);
        rst = 1'b0;
        idle();

        // R2: full memory sweep
        for (int a = 0; a < 128; a++) bus_wr(1'b1, 1'b0, 1'b0, 7'(a), mem_pat(a));
        for (int a = 0; a < 128; a++) begin
            bus_rd(1'b0, 7'(a), q, oe);
            check("R2 mem read", q, mem_pat(a));
            check("R8 oe on read", {7'b0, oe}, 8'h01);
        end
        idle();

        // R1: unselected combinations change nothing, oe stays low
        for (int c = 0; c < 3; c++) begin
            logic ce, cen;
            ce  = (c == 2);
            cen = (c != 0);
            bus_wr(ce, cen, 1'b0, 7'd5, ~mem_pat(5));
            bus_wr(ce, cen, 1'b1, 7'd1, 8'hFF);
            check("R1 no dir write", gpio0_oe, 8'h00);
            @(negedge clk);
            chip_en = ce; chip_en_n = cen; rd_wr = 1'b1; mem_sel_n = 1'b0; addr = 7'd5;
            #1;
            check("R1 oe unselected", {7'b0, rdata_oe}, 8'h00);
            idle();
            bus_rd(1'b0, 7'd5, q, oe);
            check("R1 mem unchanged", q, mem_pat(5));
            idle();
        end

        // R4 R5 R6: sweep direction / value / pad patterns on both ports
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 16; i++) begin
                logic [7:0] dir, val, ext, act_oe, act_out;
                dir = 8'(i * 17) ^ 8'(p * 8'h5A);
                val = ~dir ^ 8'(i * 3);
                ext = 8'(i * 29 + 7);
                bus_wr(1'b1, 1'b0, 1'b1, 7'(p * 2 + 1), dir);
                bus_wr(1'b1, 1'b0, 1'b1, 7'(p * 2), val);
                if (p == 0) gpio0_in = ext; else gpio1_in = ext;
                act_oe  = (p == 0) ? gpio0_oe  : gpio1_oe;
                act_out = (p == 0) ? gpio0_out : gpio1_out;
                check("R4 drive enable", act_oe, dir);
                check("R4 output value", act_out, val);
                bus_rd(1'b1, 7'(p * 2), q, oe);
                check("R5 pin level", q, (dir & val) | (~dir & ext));
                bus_rd(1'b1, 7'(p * 2 + 1), q, oe);
                check("R6 dir readback", q, dir);
                idle();
            end
        end
        gpio0_in = 8'hFF; gpio1_in = 8'hFF;

        // R3: upper address bits ignored in the register group
        bus_wr(1'b1, 1'b0, 1'b1, 7'h79, 8'h96);
        bus_rd(1'b1, 7'h01, q, oe);
        check("R3 alias dir write", q, 8'h96);
        bus_wr(1'b1, 1'b0, 1'b1, 7'h4A, 8'h3C);
        check("R3 alias val write port1", gpio1_out, 8'h3C);
        bus_rd(1'b1, 7'h73, q, oe);
        check("R3 alias dir read port1", q, gpio1_oe);
        idle();

        // R10: port writes did not disturb RAM; RAM write keeps ports
        bus_rd(1'b0, 7'd0, q, oe);
        check("R10 mem after port writes", q, mem_pat(0));
        bus_rd(1'b0, 7'd3, q, oe);
        check("R10 mem after port writes", q, mem_pat(3));
        idle();
        save_v = gpio0_out; save_d = gpio0_oe;
        bus_wr(1'b1, 1'b0, 1'b0, 7'd1, 8'h00);
        check("R10 port val after mem write", gpio0_out, save_v);
        check("R10 port dir after mem write", gpio0_oe, save_d);

        // R9: neighbour group
        aux_rdata = 8'hC3;
        bus_rd(1'b1, 7'h04, q, oe);
        check("R9 aux read data", q, 8'hC3);
        check("R9 aux_sel", {7'b0, aux_sel}, 8'h01);
        idle();
        #1;
        check("R9 aux_sel idle", {7'b0, aux_sel}, 8'h00);
        bus_wr(1'b1, 1'b0, 1'b1, 7'h05, 8'h00);
        check("R9 aux write port val", gpio0_out, save_v);
        check("R9 aux write port dir", gpio0_oe, save_d);
        bus_rd(1'b0, 7'd5, q, oe);
        check("R9 aux write mem", q, mem_pat(5));
        idle();

        // R7: reset again clears everything
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        #1;
        check("R7 gpio0_oe", gpio0_oe, 8'h00);
        check("R7 gpio1_out", gpio1_out, 8'h00);
        bus_rd(1'b1, 7'd3, q, oe);
        check("R7 dir read after reset", q, 8'h00);
        gpio1_in = 8'h6D;
        bus_rd(1'b1, 7'd2, q, oe);
        check("R7 all inputs after reset", q, 8'h6D);
        idle();

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule